// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block watches two independent memory ports, left and right, each with an active-low chip enable, an active-low write strobe and an address. When both ports are enabled on the same address, it decides which port keeps the location. It pulls an active-low busy flag on the other port and withholds that port's internal write enable. The decision looks only at enables and addresses, so a read collides with a write exactly as two writes would. The port whose access was already in place on the previous clock keeps the location. When both arrive on the same clock, the left port wins.

A strap input selects between two modes. In master mode the block arbitrates and drives the busy flags. In slave mode it does no arbitration. Its busy outputs stay inactive, and each port's busy input becomes a write-inhibit input. Several slave devices can then follow the decision of one master. The address width and the number of low address bits compared are parameters. All outputs are registered and change one clock after the inputs that cause them.

Top module: `dpa_arbiter`

## Requirements
- R1: If either chip enable is high or the compared address bits differ in a cycle, both busy outputs are high (inactive) after the next rising edge.
- R2: When a match first appears in master mode, the port that was not already enabled on the same address in the previous cycle gets its busy output low after the next edge. The port that was already there keeps its busy output high.
- R3: The two busy outputs are never low at the same time.
- R4: The write strobes do not affect which port is marked busy. The same enable and address sequence gives the same busy outputs for reads and for writes.
- R5: A port's write enable output (active high) goes high after the edge that follows a cycle in which that port has chip enable low, write strobe low and is not the losing port. The write enable of a port whose busy output is low is always low.
- R6: With the mode strap low (slave), no arbitration takes place. Both busy outputs are high after the next edge, even for matching addresses.
- R7: In slave mode, a low busy input on a port keeps that port's write enable low after the next edge. A high busy input lets writes through as in R5.
- R8: If both ports begin the matching access in the same cycle, the left port wins and the right busy output goes low.
- R9: Once a port is marked busy, the flag holds while the match persists. It returns high after the edge that follows the first cycle without a match.
- R10: After reset, both busy outputs are high and both write enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_sel | input | 1 | Mode strap: 1 master (arbitrate), 0 slave (busy inputs inhibit writes) |
| left_ce_n | input | 1 | Left chip enable, active low |
| left_we_n | input | 1 | Left write strobe, active low |
| left_addr | input | ADDR_W | Left address |
| left_busy_in_n | input | 1 | Left write inhibit in slave mode, active low |
| left_busy_n | output | 1 | Left busy flag, active low |
| left_wr_en | output | 1 | Left internal write enable, active high |
| right_ce_n | input | 1 | Right chip enable, active low |
| right_we_n | input | 1 | Right write strobe, active low |
| right_addr | input | ADDR_W | Right address |
| right_busy_in_n | input | 1 | Right write inhibit in slave mode, active low |
| right_busy_n | output | 1 | Right busy flag, active low |
| right_wr_en | output | 1 | Right internal write enable, active high |

## Verification
Every output of this block is due exactly one clock after the input cycle that decides it. This covers both busy flags and both write enables, in master and slave mode alike. The bench drives a cycle on the falling edge and computes the expected flags and enables from its own age-based model of who arrived first. It queues that result. A monitor pops the result one nanosecond after the next rising edge, so each comparison lands in the cycle the registered output is due.

// File: rtl/dpa_pkg.sv
package dpa_pkg;

  typedef enum logic [1:0] {
    GRANT_NONE  = 2'd0,
    GRANT_LEFT  = 2'd1,
    GRANT_RIGHT = 2'd2
  } grant_e;

  // Winner of a fresh collision: the port already in place keeps it, ties go left.
  function automatic grant_e pick_winner(input logic l_held, input logic r_held);
    if (r_held && !l_held) return GRANT_RIGHT;
    return GRANT_LEFT;
  endfunction

  // Next arbitration state from mode, match and the current state.
  function automatic grant_e next_grant(input logic master, input logic match,
                                        input grant_e cur, input logic l_held,
                                        input logic r_held);
    if (!master || !match) return GRANT_NONE;
    if (cur != GRANT_NONE) return cur;
    return pick_winner(l_held, r_held);
  endfunction

  // Port index 0 is left, 1 is right: is that port the loser in state g?
  function automatic logic port_blocked(input grant_e g, input int unsigned idx);
    if (idx == 0) return (g == GRANT_RIGHT);
    return (g == GRANT_LEFT);
  endfunction

endpackage

// File: rtl/dpa_port_track.sv
module dpa_port_track #(
  parameter int unsigned CMP_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_n,
  input  logic [CMP_W-1:0] addr,
  output logic             held
);
  logic             prev_act;
  logic [CMP_W-1:0] prev_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_act  <= 1'b0;
      prev_addr <= '0;
    end else begin
      prev_act  <= !ce_n;
      prev_addr <= addr;
    end
  end

  // Active now on the same address it was active on last cycle.
  assign held = !ce_n && prev_act && (prev_addr == addr);

endmodule

// File: rtl/dpa_grant_fsm.sv
module dpa_grant_fsm
  import dpa_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   master,
  input  logic   match,
  input  logic   l_held,
  input  logic   r_held,
  output grant_e grant_q,
  output grant_e grant_nxt
);
  assign grant_nxt = next_grant(master, match, grant_q, l_held, r_held);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) grant_q <= GRANT_NONE;
    else        grant_q <= grant_nxt;
  end

  // R2
  later_port_loses_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master && match && grant_q == GRANT_NONE && r_held && !l_held)
      |=> grant_q == GRANT_RIGHT);

  // R8
  tie_goes_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master && match && grant_q == GRANT_NONE && !r_held && !l_held)
      |=> grant_q == GRANT_LEFT);

  // R9
  grant_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master && match && grant_q != GRANT_NONE) |=> $stable(grant_q));

endmodule

// File: rtl/dpa_write_gate.sv
module dpa_write_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic master,
  input  logic ce_n,
  input  logic we_n,
  input  logic lost_nxt,
  input  logic busy_in_n,
  output logic wr_en_q
);
  logic wr_req;
  logic allow;

  assign wr_req = !ce_n && !we_n;
  assign allow  = master ? !lost_nxt : busy_in_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_en_q <= 1'b0;
    else        wr_en_q <= wr_req && allow;
  end

  // R7
  slave_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!master && !busy_in_n) |=> !wr_en_q);

endmodule

// File: rtl/dpa_arbiter.sv
module dpa_arbiter
  import dpa_pkg::*;
#(
  parameter int unsigned ADDR_W = 14,
  parameter int unsigned CMP_W  = ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_sel,
  input  logic              left_ce_n,
  input  logic              left_we_n,
  input  logic [ADDR_W-1:0] left_addr,
  input  logic              left_busy_in_n,
  output logic              left_busy_n,
  output logic              left_wr_en,
  input  logic              right_ce_n,
  input  logic              right_we_n,
  input  logic [ADDR_W-1:0] right_addr,
  input  logic              right_busy_in_n,
  output logic              right_busy_n,
  output logic              right_wr_en
);
  localparam int unsigned NPORT = 2;

  logic [NPORT-1:0] ce_n_v;
  logic [NPORT-1:0] we_n_v;
  logic [NPORT-1:0] bin_n_v;
  logic [NPORT-1:0] held_v;
  logic [NPORT-1:0] wr_v;
  logic [CMP_W-1:0] addr_v [NPORT];

  assign ce_n_v  = {right_ce_n, left_ce_n};
  assign we_n_v  = {right_we_n, left_we_n};
  assign bin_n_v = {right_busy_in_n, left_busy_in_n};
  assign addr_v[0] = left_addr[CMP_W-1:0];
  assign addr_v[1] = right_addr[CMP_W-1:0];

  // Collision: both enabled on the same compared address bits.
  logic match;
  assign match = !ce_n_v[0] && !ce_n_v[1] && (addr_v[0] == addr_v[1]);

  grant_e grant_q;
  grant_e grant_nxt;

  genvar g;
  generate
    for (g = 0; g < NPORT; g++) begin : g_port
      dpa_port_track #(.CMP_W(CMP_W)) u_track (
        .clk   (clk),
        .rst_n (rst_n),
        .ce_n  (ce_n_v[g]),
        .addr  (addr_v[g]),
        .held  (held_v[g])
      );

      dpa_write_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .master    (master_sel),
        .ce_n      (ce_n_v[g]),
        .we_n      (we_n_v[g]),
        .lost_nxt  (port_blocked(grant_nxt, g)),
        .busy_in_n (bin_n_v[g]),
        .wr_en_q   (wr_v[g])
      );
    end
  endgenerate

  dpa_grant_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .master    (master_sel),
    .match     (match),
    .l_held    (held_v[0]),
    .r_held    (held_v[1]),
    .grant_q   (grant_q),
    .grant_nxt (grant_nxt)
  );

  assign left_busy_n  = !port_blocked(grant_q, 0);
  assign right_busy_n = !port_blocked(grant_q, 1);
  assign left_wr_en   = wr_v[0];
  assign right_wr_en  = wr_v[1];

  // R1
  no_match_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (left_ce_n || right_ce_n || (left_addr[CMP_W-1:0] != right_addr[CMP_W-1:0]))
      |=> (left_busy_n && right_busy_n));

  // R3
  busy_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (left_busy_n || right_busy_n));

  // R5
  left_loser_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !left_busy_n |-> !left_wr_en);

  // R5
  right_loser_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !right_busy_n |-> !right_wr_en);

  // R6
  slave_no_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !master_sel |=> (left_busy_n && right_busy_n));

endmodule

// File: tb/dpa_arbiter_test.sv
module dpa_arbiter_test;
  localparam int AW = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master_sel = 1'b1;
  logic left_ce_n = 1'b1, left_we_n = 1'b1, left_busy_in_n = 1'b1;
  logic right_ce_n = 1'b1, right_we_n = 1'b1, right_busy_in_n = 1'b1;
  logic [AW-1:0] left_addr = '0, right_addr = '0;
  logic left_busy_n, left_wr_en, right_busy_n, right_wr_en;

  always #2.5 clk = ~clk;

  dpa_arbiter #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .master_sel(master_sel),
    .left_ce_n(left_ce_n), .left_we_n(left_we_n), .left_addr(left_addr),
    .left_busy_in_n(left_busy_in_n), .left_busy_n(left_busy_n), .left_wr_en(left_wr_en),
    .right_ce_n(right_ce_n), .right_we_n(right_we_n), .right_addr(right_addr),
    .right_busy_in_n(right_busy_in_n), .right_busy_n(right_busy_n), .right_wr_en(right_wr_en)
  );

  typedef struct {
    logic lb, rb, lw, rw;
    string tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit  done = 0;

  // Independent model: age of each port's current access, decision state.
  int lage = -1, rage = -1;
  logic [AW-1:0] pla = '0, pra = '0;
  int dec = 0; // 0 none, 1 left keeps, 2 right keeps

  task automatic check(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic lce, input logic lwe, input int la,
                      input logic rce, input logic rwe, input int ra,
                      input logic lbi, input logic rbi, input string tag);
    exp_t e;
    logic match;
    @(negedge clk);
    master_sel = m; left_ce_n = lce; left_we_n = lwe; left_addr = AW'(la);
    right_ce_n = rce; right_we_n = rwe; right_addr = AW'(ra);
    left_busy_in_n = lbi; right_busy_in_n = rbi;
    lage = !lce ? ((lage >= 0 && pla == AW'(la)) ? lage + 1 : 0) : -1;
    rage = !rce ? ((rage >= 0 && pra == AW'(ra)) ? rage + 1 : 0) : -1;
    pla = AW'(la); pra = AW'(ra);
    match = !lce && !rce && (AW'(la) == AW'(ra));
    if (!m || !match) dec = 0;
    else if (dec == 0) dec = (rage > 0 && lage == 0) ? 2 : 1;
    e.lb = (dec != 2);
    e.rb = (dec != 1);
    e.lw = !lce && !lwe && (m ? (dec != 2) : lbi);
    e.rw = !rce && !rwe && (m ? (dec != 1) : rbi);
    e.tag = tag;
    q.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        check(e.tag, left_busy_n, e.lb, "left_busy_n");
        check(e.tag, right_busy_n, e.rb, "right_busy_n");
        check(e.tag, left_wr_en, e.lw, "left_wr_en");
        check(e.tag, right_wr_en, e.rw, "right_wr_en");
        // R3: never both busy
        check("R3", left_busy_n | right_busy_n, 1'b1, "busy exclusive");
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    #1;
    // R10: reset state
    check("R10", left_busy_n, 1'b1, "left_busy_n reset");
    check("R10", right_busy_n, 1'b1, "right_busy_n reset");
    check("R10", left_wr_en, 1'b0, "left_wr_en reset");
    check("R10", right_wr_en, 1'b0, "right_wr_en reset");
    @(negedge clk); rst_n = 1'b1;

    // R1/R5: different addresses, both writing
    step(1, 0,0,16'h0010, 0,0,16'h0011, 1,1, "R1");
    step(1, 0,0,16'h0100, 0,0,16'h0200, 1,1, "R5");
    // R1: same address but right disabled
    step(1, 0,0,16'h0033, 1,0,16'h0033, 1,1, "R1");
    step(1, 1,1,0, 1,1,0, 1,1, "R1");
    // R2/R5/R9: left first, right joins writing -> right busy, held
    step(1, 0,0,16'h0005, 1,1,0, 1,1, "R2");
    step(1, 0,0,16'h0005, 1,1,0, 1,1, "R2");
    step(1, 0,0,16'h0005, 0,0,16'h0005, 1,1, "R2");
    step(1, 0,1,16'h0005, 0,0,16'h0005, 1,1, "R9");
    step(1, 0,0,16'h0005, 0,0,16'h0005, 1,1, "R5");
    step(1, 1,1,16'h0005, 0,0,16'h0005, 1,1, "R9");
    step(1, 1,1,0, 1,1,0, 1,1, "R9");
    // R2: right first, left joins -> left busy, released on address change
    step(1, 1,1,0, 0,0,16'h3ffe, 1,1, "R2");
    step(1, 0,0,16'h3ffe, 0,0,16'h3ffe, 1,1, "R2");
    step(1, 0,0,16'h3ffe, 0,1,16'h3ffe, 1,1, "R9");
    step(1, 0,0,16'h3ffe, 0,0,16'h3ffd, 1,1, "R9");
    step(1, 1,1,0, 1,1,0, 1,1, "R1");
    // R8: both arrive in the same cycle -> left wins
    step(1, 0,0,16'h1234, 0,0,16'h1234, 1,1, "R8");
    step(1, 0,0,16'h1234, 0,0,16'h1234, 1,1, "R8");
    step(1, 1,1,0, 1,1,0, 1,1, "R8");
    // R4: same sequence as the R2 case with reads only
    step(1, 0,1,16'h0005, 1,1,0, 1,1, "R4");
    step(1, 0,1,16'h0005, 0,1,16'h0005, 1,1, "R4");
    step(1, 0,1,16'h0005, 0,1,16'h0005, 1,1, "R4");
    step(1, 1,1,0, 1,1,0, 1,1, "R4");
    // R4: left reads first, right joins writing
    step(1, 0,1,16'h0777, 1,1,0, 1,1, "R4");
    step(1, 0,1,16'h0777, 0,0,16'h0777, 1,1, "R4");
    step(1, 1,1,0, 1,1,0, 1,1, "R4");
    // R6/R7: slave mode, matching addresses, busy inputs high -> writes pass
    step(0, 0,0,16'h0042, 0,0,16'h0042, 1,1, "R6");
    step(0, 0,0,16'h0042, 0,0,16'h0042, 1,1, "R6");
    // R7: busy inputs low block writes per port
    step(0, 0,0,16'h0042, 0,0,16'h0042, 0,1, "R7");
    step(0, 0,0,16'h0010, 0,0,16'h0020, 1,0, "R7");
    step(0, 0,0,16'h0010, 0,0,16'h0020, 0,0, "R7");
    step(0, 1,1,0, 1,1,0, 1,1, "R7");
    // back to master: busy inputs ignored
    step(1, 0,0,16'h0099, 0,0,16'h0098, 0,0, "R5");
    step(1, 1,1,0, 1,1,0, 1,1, "R1");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule